// File: doc/BRIEF.md
# Dual-Lane Double-Edge Write Frame Serializer

This block sits on the host side of a narrow serial display link. It takes one parallel-bus request at a time and turns it into a short frame on two serial data lanes. A request carries a 16-bit data word, an address/data select, a read/write flag and two active-low chip selects. Each lane sends one bit on every edge of the link clock. The block runs on a bit clock at twice the link-clock rate, so each of its clock cycles is one bit slot.

A write frame fills ten slots per lane, which is five link-clock cycles. The first two slots of each lane hold control bits, and the remaining eight hold one byte of data, least significant bit first. A read command sends only the two control slots. The chip-select identity is packed into a single bit.

A busy output paces the host so that frames start at least six link-clock cycles apart. When no frame is in flight, both lanes rest at logic high. A request that selects both targets, or neither target, is dropped and raises a one-cycle error pulse.

Top module: `duallane_frame_ser`

## Requirements
- R1: After reset, and whenever busy is low, both lanes are high. Busy and the error pulse are low out of reset.
- R2: A request is taken on a clock edge where valid is high and busy is low. The first slot of its frame appears on the lanes in the cycle after that edge, and busy rises in the same cycle.
- R3: Lane 0 sends slot 0 = 0 (start bit), slot 1 = address/data select, and slots 2 to 9 = data bits 0 to 7 in that order.
- R4: Lane 1 sends slot 0 = read/write flag (1 = read, 0 = write), slot 1 = chip-select bit, and slots 2 to 9 = data bits 8 to 15 in that order.
- R5: The chip-select bit is 1 when only chip select 1 is low, and 0 when only chip select 2 is low.
- R6: A read command sends only slots 0 and 1. Both lanes are high from slot 2 onward, whatever the data input holds.
- R7: Busy is high for slots 0 to 10 of a frame (11 bit-clock cycles) and low from slot 11. A request presented while busy is high is ignored: it produces no frame.
- R8: A request with both chip selects low, or both high, while busy is low starts no frame. It raises the error output for exactly the next cycle, and the lanes stay high.
- R9: With valid held high, successive frames start exactly 12 bit-clock cycles (6 link-clock cycles) apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, twice the link-clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_data | input | 16 | Data word to send |
| req_ad | input | 1 | Address/data select |
| req_rd | input | 1 | 1 = read command, 0 = write |
| req_cs1_n | input | 1 | Chip select 1, active low |
| req_cs2_n | input | 1 | Chip select 2, active low |
| busy | output | 1 | High while a new request would be refused |
| lane0 | output | 1 | Serial lane 0, one bit per bit-clock cycle |
| lane1 | output | 1 | Serial lane 1, one bit per bit-clock cycle |
| cs_err | output | 1 | One-cycle pulse for a dropped chip-select request |

## Verification
The bench sweeps walking-one and dense data words across every combination of address/data, read/write and chip-select target. It compares every slot of both lanes against bit positions worked out from the frame layout. This catches a lane swap, a bit order reversed to MSB first, an off-by-one slot shift, or a read command that leaks payload bits. During each frame, an intruding request is driven while busy is high. A design that samples requests without checking busy would start a second frame, which shows up as a low start bit where the lanes should be idle. Back-to-back requests check that the frame period is exactly twelve cycles, because a busy window that is one cycle short or long moves the second start bit. Both illegal chip-select patterns check that the request is dropped with a single-cycle error pulse and no frame.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

    localparam int LANE_COUNT = 2;
    localparam int HDR_SLOTS  = 2;

    typedef enum logic [1:0] {
        CSEL_NONE = 2'b00,
        CSEL_ONE  = 2'b01,
        CSEL_TWO  = 2'b10,
        CSEL_BOTH = 2'b11
    } csel_e;

    function automatic csel_e csel_of(input logic cs1_n, input logic cs2_n);
        csel_e r;
        r = csel_e'({~cs2_n, ~cs1_n});
        return r;
    endfunction

endpackage

// File: rtl/lfs_cs_decode.sv
module lfs_cs_decode
    import lfs_pkg::*;
(
    input  logic cs1_n,
    input  logic cs2_n,
    output logic legal,
    output logic cs_bit
);
    csel_e sel;

    always_comb begin
        sel    = csel_of(cs1_n, cs2_n);
        legal  = 1'b0;
        cs_bit = 1'b0;
        case (sel)
            CSEL_ONE: begin
                legal  = 1'b1;
                cs_bit = 1'b1;
            end
            CSEL_TWO: begin
                legal  = 1'b1;
                cs_bit = 1'b0;
            end
            default: begin
                legal  = 1'b0;
                cs_bit = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/lfs_frame_builder.sv
module lfs_frame_builder
    import lfs_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int PAY_W = DATA_W / LANE_COUNT,
    localparam int FRAME_SLOTS = HDR_SLOTS + PAY_W
) (
    input  logic [DATA_W-1:0] data,
    input  logic              ad,
    input  logic              rd,
    input  logic              cs_bit,
    output logic [LANE_COUNT-1:0][FRAME_SLOTS-1:0] words
);
    logic [LANE_COUNT-1:0][HDR_SLOTS-1:0] hdr;

    // bit 0 of each header goes out first
    always_comb begin
        hdr[0] = {ad, 1'b0};
        hdr[1] = {cs_bit, rd};
    end

    for (genvar l = 0; l < LANE_COUNT; l++) begin : g_lane
        logic [PAY_W-1:0] pay;
        always_comb begin
            pay      = rd ? {PAY_W{1'b1}} : data[l*PAY_W +: PAY_W];
            words[l] = {pay, hdr[l]};
        end
    end
endmodule

// File: rtl/lfs_slot_shifter.sv
module lfs_slot_shifter
    import lfs_pkg::*;
#(
    parameter int FRAME_SLOTS = 10,
    parameter int GAP_CYCLES  = 6,
    localparam int BUSY_SLOTS = 2 * GAP_CYCLES - 1,
    localparam int CNT_W      = $clog2(BUSY_SLOTS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic [LANE_COUNT-1:0][FRAME_SLOTS-1:0] words,
    output logic [LANE_COUNT-1:0] lane_o,
    output logic busy_o
);
    typedef struct packed {
        logic [LANE_COUNT-1:0][FRAME_SLOTS-1:0] sh;
        logic [LANE_COUNT-1:0]                  lane;
        logic [CNT_W-1:0]                       cnt;
        logic                                   busy;
    } shf_t;

    shf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            for (int l = 0; l < LANE_COUNT; l++) begin
                st_d.lane[l] = words[l][0];
                st_d.sh[l]   = {1'b1, words[l][FRAME_SLOTS-1:1]};
            end
            st_d.cnt  = CNT_W'(BUSY_SLOTS - 1);
            st_d.busy = 1'b1;
        end else begin
            for (int l = 0; l < LANE_COUNT; l++) begin
                st_d.lane[l] = st_q.sh[l][0];
                st_d.sh[l]   = {1'b1, st_q.sh[l][FRAME_SLOTS-1:1]};
            end
            if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end else begin
                st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sh   <= '1;
            st_q.lane <= '1;
            st_q.cnt  <= '0;
            st_q.busy <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lane_o = st_q.lane;
    assign busy_o = st_q.busy;

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (&lane_o)); // R1

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |=> busy_o); // R7

endmodule

// File: rtl/duallane_frame_ser.sv
module duallane_frame_ser
    import lfs_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int GAP_CYCLES = 6,
    localparam int PAY_W       = DATA_W / LANE_COUNT,
    localparam int FRAME_SLOTS = HDR_SLOTS + PAY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [DATA_W-1:0] req_data,
    input  logic              req_ad,
    input  logic              req_rd,
    input  logic              req_cs1_n,
    input  logic              req_cs2_n,
    output logic              busy,
    output logic              lane0,
    output logic              lane1,
    output logic              cs_err
);
    typedef struct packed {
        logic err;
    } top_t;

    top_t st_d, st_q;

    logic legal, cs_bit, take, load;
    logic [LANE_COUNT-1:0][FRAME_SLOTS-1:0] words;
    logic [LANE_COUNT-1:0] lanes;
    logic busy_w;

    lfs_cs_decode u_dec (
        .cs1_n  (req_cs1_n),
        .cs2_n  (req_cs2_n),
        .legal  (legal),
        .cs_bit (cs_bit)
    );

    lfs_frame_builder #(.DATA_W(DATA_W)) u_bld (
        .data   (req_data),
        .ad     (req_ad),
        .rd     (req_rd),
        .cs_bit (cs_bit),
        .words  (words)
    );

    always_comb begin
        take     = req_valid && !busy_w;
        load     = take && legal;
        st_d     = st_q;
        st_d.err = take && !legal;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.err <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    lfs_slot_shifter #(
        .FRAME_SLOTS (FRAME_SLOTS),
        .GAP_CYCLES  (GAP_CYCLES)
    ) u_shf (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .words  (words),
        .lane_o (lanes),
        .busy_o (busy_w)
    );

    assign busy   = busy_w;
    assign lane0  = lanes[0];
    assign lane1  = lanes[1];
    assign cs_err = st_q.err;

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !lane0); // R3

    AST_RW_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (lane1 == $past(req_rd))); // R4

    AST_ERR_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        cs_err |-> (!busy && lane0 && lane1)); // R8

endmodule

// File: tb/tb_duallane_frame_ser.sv
module tb_duallane_frame_ser;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [15:0] req_data = '0;
    logic req_ad = 1'b0, req_rd = 1'b0, req_cs1_n = 1'b1, req_cs2_n = 1'b1;
    logic busy, lane0, lane1, cs_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    duallane_frame_ser dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_data(req_data),
        .req_ad(req_ad), .req_rd(req_rd), .req_cs1_n(req_cs1_n), .req_cs2_n(req_cs2_n),
        .busy(busy), .lane0(lane0), .lane1(lane1), .cs_err(cs_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_l0(input int k, input logic [15:0] d, input logic ad, input logic rd);
        if (k == 0) return 1'b0;
        if (k == 1) return ad;
        if (k < 10 && !rd) return d[k-2];
        return 1'b1;
    endfunction

    function automatic logic exp_l1(input int k, input logic [15:0] d, input logic rd, input logic c1);
        if (k == 0) return rd;
        if (k == 1) return c1;
        if (k < 10 && !rd) return d[8+k-2];
        return 1'b1;
    endfunction

    task automatic run_frame(input logic [15:0] d, input logic ad, input logic rd, input logic c1);
        @(negedge clk);
        req_valid = 1'b1; req_data = d; req_ad = ad; req_rd = rd;
        req_cs1_n = ~c1; req_cs2_n = c1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 12; k++) begin
            if (k > 0) @(negedge clk);
            check(rd ? "R6 lane0" : "R3 lane0", 32'(lane0), 32'(exp_l0(k, d, ad, rd)));
            check(rd ? "R6 lane1" : (k == 1 ? "R5 cs bit" : "R4 lane1"),
                  32'(lane1), 32'(exp_l1(k, d, rd, c1)));
            check("R7 busy window", 32'(busy), 32'(k <= 10));
            if (k == 3) begin
                req_valid = 1'b1; req_data = ~d; req_ad = ~ad; req_rd = 1'b0;
            end
            if (k == 4) req_valid = 1'b0;
        end
        @(negedge clk);
        check("R7 intruder ignored lane0", 32'(lane0), 32'd1);
        check("R1 idle lane1", 32'(lane1), 32'd1);
        check("R1 idle busy", 32'(busy), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] pats [19];
        for (int i = 0; i < 16; i++) pats[i] = 16'(1) << i;
        pats[16] = 16'h0000; pats[17] = 16'hFFFF; pats[18] = 16'hA5C3;

        repeat (3) @(negedge clk);
        check("R1 reset lane0", 32'(lane0), 32'd1);
        check("R1 reset lane1", 32'(lane1), 32'd1);
        check("R1 reset busy", 32'(busy), 32'd0);
        check("R1 reset err", 32'(cs_err), 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R3 R4 R5 R6 R7 sweep
        for (int v = 0; v < 19; v++)
            for (int m = 0; m < 8; m++)
                run_frame(pats[v], m[0], m[1], m[2]);

        // R8: both selects low, then neither
        for (int c = 0; c < 2; c++) begin
            @(negedge clk);
            req_valid = 1'b1; req_data = 16'h1234; req_rd = 1'b0;
            req_cs1_n = (c == 1); req_cs2_n = (c == 1);
            @(negedge clk);
            req_valid = 1'b0; req_cs1_n = 1'b1; req_cs2_n = 1'b1;
            check("R8 err pulse", 32'(cs_err), 32'd1);
            check("R8 no busy", 32'(busy), 32'd0);
            check("R8 lane0 high", 32'(lane0), 32'd1);
            @(negedge clk);
            check("R8 err one cycle", 32'(cs_err), 32'd0);
            check("R8 still idle", 32'(lane0 & lane1), 32'd1);
        end

        // R9: held valid gives 12-cycle period
        @(negedge clk);
        req_valid = 1'b1; req_data = 16'h00FF; req_ad = 1'b1; req_rd = 1'b0;
        req_cs1_n = 1'b0; req_cs2_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k <= 24; k++) begin
            if (k > 0) @(negedge clk);
            if (k == 0 || k == 12 || k == 24) begin
                check("R9 start bit", 32'(lane0), 32'd0);
                check("R9 busy at start", 32'(busy), 32'd1);
                check("R2 rw slot", 32'(lane1), 32'd0);
            end
            if (k == 11 || k == 23) begin
                check("R9 gap busy low", 32'(busy), 32'd0);
                check("R9 gap lane0", 32'(lane0), 32'd1);
            end
        end
        req_valid = 1'b0;
        repeat (14) @(negedge clk);
        check("R1 final idle", 32'(lane0 & lane1 & ~busy), 32'd1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule